// File: doc/BRIEF.md
# Load-Store Request Merger with Alignment Bypass

This block sits in the load-store path of a CPU. It combines the core's own memory requests and the requests of an attached coprocessor into a single data-bus request with a valid/ready handshake. Core requests go through an aligner. The aligner places store data and byte enables on the correct bus lanes. When a core access crosses a 32-bit word boundary, the aligner issues it as two bus transactions. Coprocessor requests join the path after the aligner. They reach the bus exactly as presented, and the coprocessor is responsible for any alignment or splitting they need.

The block also drives a misaligned-access flag for a downstream protection checker. For core requests, the flag marks split accesses and odd-address halfwords. For coprocessor requests, the flag is raised when either of the two attribute bits is set. Attribute bit 1 means the request is not naturally aligned. Attribute bit 0 means the coprocessor modified the transaction.

Top module: `lsu_req_merge`

## Requirements
- R1: After reset, and whenever neither requester is valid, `bus_valid_o`, `core_ready_o`, `cop_ready_o` and `misaligned_o` are low.
- R2: For a core access, the size code is 0 for a byte, 1 for a halfword and 2 for a word. The bus address is the request address with bits [1:0] cleared. The byte enables are 0001, 0011 or 1111 (by size) shifted left by address bits [1:0]. The store data is rotated left by 8 times address bits [1:0].
- R3: A core access whose shifted byte enables extend past lane 3 is sent as two transactions. The first goes to the word address and carries the lanes that fit. The second goes to the word address plus 4 and carries the lanes that spilled over. `core_ready_o` rises only on the second transaction.
- R4: A selected coprocessor request drives address, write flag, byte enables and write data onto the bus unchanged. It is never split, and `cop_ready_o` follows `bus_ready_i`.
- R5: A valid coprocessor request wins over a core request, with two exceptions. The second half of a split core access keeps the bus. A request already stalled on the bus also keeps it.
- R6: While `bus_valid_o` is high and `bus_ready_i` is low, the bus outputs stay valid and unchanged in the next cycle.
- R7: For core requests, `misaligned_o` is high on both halves of a split access and on a halfword at an odd address. It is low for aligned core accesses.
- R8: For a coprocessor request, `misaligned_o` is high exactly when either attribute bit is set.
- R9: While a coprocessor request is selected, `core_ready_o` stays low and no split of the waiting core access begins. Once the core regains the bus, its access starts with the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid_i | input | 1 | Core request valid |
| core_ready_o | output | 1 | Core request completed this cycle |
| core_addr_i | input | 32 | Core byte address |
| core_we_i | input | 1 | Core write flag |
| core_size_i | input | 2 | Core access size code (0 byte, 1 half, 2 word) |
| core_wdata_i | input | 32 | Core store data, right-justified |
| cop_valid_i | input | 1 | Coprocessor request valid |
| cop_ready_o | output | 1 | Coprocessor request accepted |
| cop_addr_i | input | 32 | Coprocessor address |
| cop_we_i | input | 1 | Coprocessor write flag |
| cop_be_i | input | 4 | Coprocessor byte enables, already lane-aligned |
| cop_wdata_i | input | 32 | Coprocessor store data, already lane-aligned |
| cop_attr_i | input | 2 | Bit 1: not naturally aligned; bit 0: modified |
| bus_valid_o | output | 1 | Bus request valid |
| bus_ready_i | input | 1 | Bus accepts request |
| bus_addr_o | output | 32 | Bus address |
| bus_we_o | output | 1 | Bus write flag |
| bus_be_o | output | 4 | Bus byte enables |
| bus_wdata_o | output | 32 | Bus store data |
| misaligned_o | output | 1 | Misaligned-access flag for the protection checker |

## Verification
The hardest case to reach is a coprocessor request that arrives in the middle of a split core access. The first half has already been accepted, and the second half still needs the bus. The stimulus starts a word access at an unaligned address. It raises the coprocessor valid right after the first half is taken, then checks that the bus shows the second core half and that the coprocessor sees no ready. A related case is a coprocessor request that appears while a core request is stalled with ready low. The stimulus reaches it by holding `bus_ready_i` low before the coprocessor request arrives.

// File: rtl/lsu_merge_pkg.sv
package lsu_merge_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned OFF_W  = $clog2(BE_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Lane mask of an access that starts at lane 0.
    function automatic logic [BE_W-1:0] size_mask(input logic [1:0] sz);
        logic [BE_W-1:0] m;
        case (sz)
            SZ_BYTE: m = BE_W'(1);
            SZ_HALF: m = BE_W'(3);
            default: m = {BE_W{1'b1}};
        endcase
        return m;
    endfunction

    // Rotate data left by a whole number of byte lanes.
    function automatic logic [DATA_W-1:0] rotate_lanes(input logic [DATA_W-1:0] d,
                                                       input logic [OFF_W-1:0]  off);
        logic [2*DATA_W-1:0] dd;
        dd = {d, d} << (32'(off) * 8);
        return dd[2*DATA_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/lsu_core_align.sv
module lsu_core_align
    import lsu_merge_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              second_i,
    output bus_req_t          req_o,
    output logic              split_need_o,
    output logic              half_odd_o
);

    logic [OFF_W-1:0]  off;
    logic [2*BE_W-1:0] wide_be;
    logic [ADDR_W-1:0] word_addr;

    always_comb begin
        off          = addr_i[OFF_W-1:0];
        wide_be      = {{BE_W{1'b0}}, size_mask(size_i)} << off;
        split_need_o = |wide_be[2*BE_W-1:BE_W];
        half_odd_o   = (size_i == SZ_HALF) && off[0];
        word_addr    = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

        req_o.we     = we_i;
        req_o.wdata  = rotate_lanes(wdata_i, off);
        if (second_i) begin
            req_o.addr = word_addr + ADDR_W'(BE_W);
            req_o.be   = wide_be[2*BE_W-1:BE_W];
        end else begin
            req_o.addr = word_addr;
            req_o.be   = wide_be[BE_W-1:0];
        end
    end

endmodule

// File: rtl/lsu_req_arb.sv
module lsu_req_arb (
    input  logic clk,
    input  logic rst,
    input  logic core_valid_i,
    input  logic cop_valid_i,
    input  logic split_need_i,
    input  logic bus_ready_i,
    output logic sel_cop_o,
    output logic split_q_o,
    output logic bus_valid_o,
    output logic core_ready_o,
    output logic cop_ready_o
);

    logic split_q;
    logic busy_q;
    logic owner_cop_q;
    logic core_fire;

    always_comb begin
        if (split_q)     sel_cop_o = 1'b0;
        else if (busy_q) sel_cop_o = owner_cop_q;
        else             sel_cop_o = cop_valid_i;

        bus_valid_o  = sel_cop_o ? cop_valid_i : core_valid_i;
        core_fire    = !sel_cop_o && core_valid_i && bus_ready_i;
        core_ready_o = core_fire && (split_q || !split_need_i);
        cop_ready_o  = sel_cop_o && cop_valid_i && bus_ready_i;
        split_q_o    = split_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q     <= 1'b0;
            busy_q      <= 1'b0;
            owner_cop_q <= 1'b0;
        end else begin
            busy_q      <= bus_valid_o && !bus_ready_i;
            owner_cop_q <= sel_cop_o;
            if (core_fire && split_q)
                split_q <= 1'b0;
            else if (core_fire && split_need_i)
                split_q <= 1'b1;
        end
    end

endmodule

// File: rtl/lsu_req_merge.sv
module lsu_req_merge
    import lsu_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_valid_i,
    output logic              core_ready_o,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic              core_we_i,
    input  logic [1:0]        core_size_i,
    input  logic [DATA_W-1:0] core_wdata_i,
    input  logic              cop_valid_i,
    output logic              cop_ready_o,
    input  logic [ADDR_W-1:0] cop_addr_i,
    input  logic              cop_we_i,
    input  logic [BE_W-1:0]   cop_be_i,
    input  logic [DATA_W-1:0] cop_wdata_i,
    input  logic [1:0]        cop_attr_i,
    output logic              bus_valid_o,
    input  logic              bus_ready_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_we_o,
    output logic [BE_W-1:0]   bus_be_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              misaligned_o
);

    bus_req_t core_req;
    bus_req_t cop_req;
    bus_req_t out_req;
    logic     split_need;
    logic     half_odd;
    logic     split_q;
    logic     sel_cop;

    lsu_core_align i_align (
        .addr_i       (core_addr_i),
        .size_i       (core_size_i),
        .we_i         (core_we_i),
        .wdata_i      (core_wdata_i),
        .second_i     (split_q),
        .req_o        (core_req),
        .split_need_o (split_need),
        .half_odd_o   (half_odd)
    );

    lsu_req_arb i_arb (
        .clk          (clk),
        .rst          (rst),
        .core_valid_i (core_valid_i),
        .cop_valid_i  (cop_valid_i),
        .split_need_i (split_need),
        .bus_ready_i  (bus_ready_i),
        .sel_cop_o    (sel_cop),
        .split_q_o    (split_q),
        .bus_valid_o  (bus_valid_o),
        .core_ready_o (core_ready_o),
        .cop_ready_o  (cop_ready_o)
    );

    always_comb begin
        cop_req.addr  = cop_addr_i;
        cop_req.we    = cop_we_i;
        cop_req.be    = cop_be_i;
        cop_req.wdata = cop_wdata_i;

        // Coprocessor traffic joins after the aligner.
        out_req = sel_cop ? cop_req : core_req;

        bus_addr_o  = out_req.addr;
        bus_we_o    = out_req.we;
        bus_be_o    = out_req.be;
        bus_wdata_o = out_req.wdata;

        if (!bus_valid_o)  misaligned_o = 1'b0;
        else if (sel_cop)  misaligned_o = |cop_attr_i;
        else               misaligned_o = split_q || split_need || half_odd;
    end

endmodule

// File: rtl/lsu_req_merge_chk.sv
module lsu_req_merge_chk (
    input logic        clk,
    input logic        rst,
    input logic        core_valid_i,
    input logic        core_ready_o,
    input logic        cop_valid_i,
    input logic        cop_ready_o,
    input logic [31:0] cop_addr_i,
    input logic [3:0]  cop_be_i,
    input logic [31:0] cop_wdata_i,
    input logic [1:0]  cop_attr_i,
    input logic        bus_valid_o,
    input logic        bus_ready_i,
    input logic [31:0] bus_addr_o,
    input logic        bus_we_o,
    input logic [3:0]  bus_be_o,
    input logic [31:0] bus_wdata_o,
    input logic        misaligned_o
);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!core_valid_i && !cop_valid_i) |-> !bus_valid_o);

    assert_second_half_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && bus_ready_i && !core_ready_o && !cop_ready_o)
        |=> (bus_valid_o && misaligned_o && bus_addr_o == $past(bus_addr_o) + 32'd4));

    assert_cop_passthru_R4: assert property (@(posedge clk) disable iff (rst)
        cop_ready_o |-> (bus_addr_o == cop_addr_i && bus_be_o == cop_be_i
                         && bus_wdata_o == cop_wdata_i));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)
            && $stable(bus_be_o) && $stable(bus_wdata_o) && $stable(bus_we_o)));

    assert_cop_flag_R8: assert property (@(posedge clk) disable iff (rst)
        cop_ready_o |-> (misaligned_o == (cop_attr_i != 2'b00)));

    assert_one_ready_R9: assert property (@(posedge clk) disable iff (rst)
        cop_ready_o |-> !core_ready_o);

endmodule

bind lsu_req_merge lsu_req_merge_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .core_valid_i (core_valid_i),
    .core_ready_o (core_ready_o),
    .cop_valid_i  (cop_valid_i),
    .cop_ready_o  (cop_ready_o),
    .cop_addr_i   (cop_addr_i),
    .cop_be_i     (cop_be_i),
    .cop_wdata_i  (cop_wdata_i),
    .cop_attr_i   (cop_attr_i),
    .bus_valid_o  (bus_valid_o),
    .bus_ready_i  (bus_ready_i),
    .bus_addr_o   (bus_addr_o),
    .bus_we_o     (bus_we_o),
    .bus_be_o     (bus_be_o),
    .bus_wdata_o  (bus_wdata_o),
    .misaligned_o (misaligned_o)
);

// File: tb/test_lsu_req_merge.sv
`timescale 1ns/1ps
module test_lsu_req_merge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_valid_i = 1'b0;
    logic        core_ready_o;
    logic [31:0] core_addr_i = '0;
    logic        core_we_i = 1'b0;
    logic [1:0]  core_size_i = '0;
    logic [31:0] core_wdata_i = '0;
    logic        cop_valid_i = 1'b0;
    logic        cop_ready_o;
    logic [31:0] cop_addr_i = '0;
    logic        cop_we_i = 1'b0;
    logic [3:0]  cop_be_i = '0;
    logic [31:0] cop_wdata_i = '0;
    logic [1:0]  cop_attr_i = '0;
    logic        bus_valid_o;
    logic        bus_ready_i = 1'b1;
    logic [31:0] bus_addr_o;
    logic        bus_we_o;
    logic [3:0]  bus_be_o;
    logic [31:0] bus_wdata_o;
    logic        misaligned_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [31:0] DATA = 32'hA1B2C3D4;

    // {addr, size, be first, be second, split, flag}
    localparam int NV = 9;
    localparam logic [43:0] VEC [NV] = '{
        {32'h0000_1000, 2'd2, 4'hF, 4'h0, 1'b0, 1'b0},
        {32'h0000_1001, 2'd2, 4'hE, 4'h1, 1'b1, 1'b1},
        {32'h0000_1002, 2'd2, 4'hC, 4'h3, 1'b1, 1'b1},
        {32'h0000_1003, 2'd2, 4'h8, 4'h7, 1'b1, 1'b1},
        {32'h0000_1002, 2'd1, 4'hC, 4'h0, 1'b0, 1'b0},
        {32'h0000_1001, 2'd1, 4'h6, 4'h0, 1'b0, 1'b1},
        {32'h0000_1003, 2'd1, 4'h8, 4'h1, 1'b1, 1'b1},
        {32'h0000_1003, 2'd0, 4'h8, 4'h0, 1'b0, 1'b0},
        {32'h0000_1000, 2'd0, 4'h1, 4'h0, 1'b0, 1'b0}
    };

    lsu_req_merge i_lsu_req_merge (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rotl(input logic [31:0] d, input logic [1:0] off);
        logic [31:0] r;
        r = d;
        for (int k = 0; k < 4; k++)
            if (k < int'(off)) r = {r[23:0], r[31:24]};
        return r;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset / idle state
        chk("R1 bus_valid", 32'(bus_valid_o), 0);
        chk("R1 core_ready", 32'(core_ready_o), 0);
        chk("R1 cop_ready", 32'(cop_ready_o), 0);
        chk("R1 flag", 32'(misaligned_o), 0);

        // R2 R3 R7: core access table
        for (int i = 0; i < NV; i++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            logic [3:0]  b1, b2;
            logic        sp, fl;
            {a, sz, b1, b2, sp, fl} = VEC[i];
            @(negedge clk);
            core_valid_i = 1'b1; core_addr_i = a; core_size_i = sz;
            core_we_i = 1'b1; core_wdata_i = DATA;
            #1;
            chk("R2 addr", bus_addr_o, a & ~32'h3);
            chk("R2 be", 32'(bus_be_o), 32'(b1));
            chk("R2 wdata", bus_wdata_o, rotl(DATA, a[1:0]));
            chk("R7 flag first", 32'(misaligned_o), 32'(fl));
            chk("R3 ready first", 32'(core_ready_o), 32'(!sp));
            if (sp) begin
                @(negedge clk); #1;
                chk("R3 addr second", bus_addr_o, (a & ~32'h3) + 32'd4);
                chk("R3 be second", 32'(bus_be_o), 32'(b2));
                chk("R3 ready second", 32'(core_ready_o), 1);
                chk("R7 flag second", 32'(misaligned_o), 1);
            end
            @(posedge clk); #1;
            core_valid_i = 1'b0;
        end

        // R4 R8: coprocessor passthrough, attribute bits
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            cop_valid_i = 1'b1; cop_addr_i = 32'h0000_9001 + 32'(t);
            cop_we_i = 1'b1; cop_be_i = 4'b0110; cop_wdata_i = 32'h1122_3344;
            cop_attr_i = 2'(t);
            #1;
            chk("R4 addr", bus_addr_o, 32'h0000_9001 + 32'(t));
            chk("R4 be", 32'(bus_be_o), 32'h6);
            chk("R4 wdata", bus_wdata_o, 32'h1122_3344);
            chk("R4 ready", 32'(cop_ready_o), 1);
            chk("R8 flag", 32'(misaligned_o), 32'(t != 0));
            @(posedge clk); #1;
            cop_valid_i = 1'b0;
        end

        // R5 R9: coprocessor wins; core split starts afresh afterwards
        @(negedge clk);
        core_valid_i = 1'b1; core_addr_i = 32'h0000_5001; core_size_i = 2'd2;
        cop_valid_i = 1'b1; cop_addr_i = 32'h0000_6002; cop_be_i = 4'b1100;
        cop_attr_i = 2'b00;
        #1;
        chk("R5 cop first", bus_addr_o, 32'h0000_6002);
        chk("R9 core waits", 32'(core_ready_o), 0);
        chk("R8 flag clear", 32'(misaligned_o), 0);
        @(posedge clk); #1; cop_valid_i = 1'b0;
        @(negedge clk); #1;
        chk("R9 first half addr", bus_addr_o, 32'h0000_5000);
        chk("R9 first half be", 32'(bus_be_o), 32'hE);
        chk("R9 no early ready", 32'(core_ready_o), 0);
        @(negedge clk); #1;
        chk("R9 second half addr", bus_addr_o, 32'h0000_5004);
        chk("R9 second ready", 32'(core_ready_o), 1);
        @(posedge clk); #1; core_valid_i = 1'b0;

        // R5: coprocessor arrives mid-split
        @(negedge clk);
        core_valid_i = 1'b1; core_addr_i = 32'h0000_7002; core_size_i = 2'd2;
        @(posedge clk); #1;
        cop_valid_i = 1'b1; cop_addr_i = 32'h0000_8000; cop_be_i = 4'hF;
        @(negedge clk); #1;
        chk("R5 split keeps bus", bus_addr_o, 32'h0000_7004);
        chk("R5 split be", 32'(bus_be_o), 32'h3);
        chk("R5 cop not ready", 32'(cop_ready_o), 0);
        chk("R5 core ready", 32'(core_ready_o), 1);
        @(posedge clk); #1; core_valid_i = 1'b0;
        @(negedge clk); #1;
        chk("R5 cop next", bus_addr_o, 32'h0000_8000);
        chk("R5 cop ready", 32'(cop_ready_o), 1);
        @(posedge clk); #1; cop_valid_i = 1'b0;

        // R6: stalled core request keeps the bus
        @(negedge clk);
        bus_ready_i = 1'b0;
        core_valid_i = 1'b1; core_addr_i = 32'h0000_3000; core_size_i = 2'd2;
        #1;
        chk("R6 valid", 32'(bus_valid_o), 1);
        chk("R6 no ready", 32'(core_ready_o), 0);
        @(negedge clk);
        cop_valid_i = 1'b1; cop_addr_i = 32'h0000_4000;
        #1;
        chk("R6 addr held", bus_addr_o, 32'h0000_3000);
        chk("R6 cop waits", 32'(cop_ready_o), 0);
        @(negedge clk);
        bus_ready_i = 1'b1;
        #1;
        chk("R6 core completes", 32'(core_ready_o), 1);
        chk("R6 core addr", bus_addr_o, 32'h0000_3000);
        @(posedge clk); #1; core_valid_i = 1'b0;
        @(negedge clk); #1;
        chk("R4 after stall", bus_addr_o, 32'h0000_4000);
        @(posedge clk); #1; cop_valid_i = 1'b0;

        @(negedge clk); #1;
        chk("R1 idle end", 32'(bus_valid_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule